// File: doc/BRIEF.md
# Boot-Configured I2C Clock Generator

This block produces the clock line of an I2C master from a fast reference clock. After reset it waits for a single load strobe. On that strobe it captures a 2-bit reference-frequency code and a speed bit, which is bit 0 of the first boot-memory byte. From these two inputs it picks a full-period divider and holds it until the next reset. While it waits, it leaves the line released. Once it is loaded, it drives the line open-drain: it either pulls the line low or lets the pull-up raise it. The high and low phases each last half the divider, counted in reference clocks.

A data shifter sits beside the block. The generator gives it one-cycle strobes at each rising and falling phase boundary. It also gives a strobe when a nine-bit frame (eight data bits plus acknowledge) ends, and a level that marks the acknowledge bit. A slave may hold the line low after a frame ends. When the generator releases the line for the first bit of the next frame, it reads the synchronized line and waits until the line is seen high. Only then does it count the high phase. During that wait it raises a stretch flag. Inside a frame, the generator does not wait on the line.

Top module: `scl_boot_gen`

## Requirements
- R1: With no stretch, each low phase and each high phase lasts exactly half the divider in reference cycles. A fall strobe comes exactly half a divider after the preceding rise strobe.
- R2: The divider is chosen by the reference code and the speed bit. Code 0 gives 1008 (speed 0) or 256 (speed 1). Code 1 gives 752 or 192. Code 2 gives 512 or 128. Code 3 gives 336 or 96. Fall strobes inside a frame are exactly one divider apart.
- R3: From reset until the load strobe, the line is released and no rise, fall or frame-end strobe appears.
- R4: After the first load, further load strobes and changes on the code and speed inputs have no effect on the period until reset.
- R5: At the first bit of every frame after the first, the generator releases the line and waits. The high phase begins two clock edges after the first edge that samples the line high. An unstretched frame-start bit therefore lasts the divider plus 3 cycles. A slave hold adds its length on top.
- R6: While the generator waits for the line at a frame start, the stretch flag is 1. Otherwise it is 0.
- R7: Rise and fall strobes last one cycle each and never coincide. Bit positions count 0 to 8 within a frame, with the load's fall strobe starting bit 0. The acknowledge flag is 1 exactly while bit 8 is clocked. The frame-end strobe fires with the fall strobe that ends bit 8.
- R8: A low hold on the line during a mid-frame bit does not shift the timing, and it does not raise the stretch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (boot) clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | One-cycle strobe that captures the divider configuration |
| refCode | input | 2 | Reference-frequency code (0=100, 1=75, 2=50, 3=33 MHz) |
| fastSel | input | 1 | Speed select: 0 standard, 1 fast |
| sclIn | input | 1 | Sampled state of the clock line |
| sclDriveLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| riseStb | output | 1 | One-cycle strobe at the start of each high phase |
| fallStb | output | 1 | One-cycle strobe at the start of each low phase |
| byteEndStb | output | 1 | One-cycle strobe when the acknowledge bit ends |
| ackSlot | output | 1 | 1 while the acknowledge bit is clocked |
| stretchActive | output | 1 | 1 while waiting for a stretching slave |

## Verification
Each of the eight code and speed combinations runs past one frame boundary. This separates the divider entries from one another, and also separates in-frame bits from the frame-start bit with its synchronizer delay. A run with a long slave hold after a frame shows that the extra time is exactly the hold length and that the stretch flag covers it. A low hold in the middle of a frame, in the same run, shows that the line is not watched there. A second load strobe with different inputs partway through a run shows that the lock holds.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int DIV_W = 11;

  typedef enum logic [1:0] {
    ST_UNCFG,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } sclState_e;

  // strobes from the phase controller to the datapath
  typedef struct packed {
    logic loadDiv;
    logic cntClr;
  } sclCtrl_t;

  // full-period divider per reference code and speed bit
  function automatic logic [DIV_W-1:0] divLookup(input logic [1:0] code,
                                                 input logic fast);
    logic [DIV_W-1:0] val;
    case ({code, fast})
      3'b000:  val = DIV_W'(1008);
      3'b001:  val = DIV_W'(256);
      3'b010:  val = DIV_W'(752);
      3'b011:  val = DIV_W'(192);
      3'b100:  val = DIV_W'(512);
      3'b101:  val = DIV_W'(128);
      3'b110:  val = DIV_W'(336);
      default: val = DIV_W'(96);
    endcase
    return val;
  endfunction

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  sclCtrl_t   ctrl,
  input  logic [1:0] refCode,
  input  logic       fastSel,
  input  logic       sclIn,
  output logic       halfDone,
  output logic       sclHigh
);

  logic [DIV_W-1:0] divVal;
  logic [DIV_W-1:0] halfVal;
  logic [DIV_W-1:0] phaseCnt;
  logic             divLocked;
  logic [SYNC_STAGES-1:0] syncQ;

  assign halfVal = divVal >> 1;

  // divider capture, once per reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal    <= '0;
      divLocked <= 1'b0;
    end else if (ctrl.loadDiv && !divLocked) begin
      divVal    <= divLookup(refCode, fastSel);
      divLocked <= 1'b1;
    end
  end

  // phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctrl.cntClr) phaseCnt <= '0;
    else                  phaseCnt <= phaseCnt + 1'b1;
  end

  assign halfDone = divLocked && (phaseCnt == halfVal - 1'b1);

  // line synchronizer, reset to the released level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
  end

  assign sclHigh = syncQ[SYNC_STAGES-1];

  p_div_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    divLocked |=> (divLocked && $stable(divVal)));

  p_div_even_r2: assert property (@(posedge clk) disable iff (!rstN)
    divLocked |-> (divVal[0] == 1'b0 && divVal != '0));

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    divLocked |-> (phaseCnt < halfVal));

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
#(
  parameter int BIT_COUNT = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgLoad,
  input  logic     halfDone,
  input  logic     sclHigh,
  output sclCtrl_t ctrl,
  output logic     sclDriveLow,
  output logic     riseStb,
  output logic     fallStb,
  output logic     byteEndStb,
  output logic     ackSlot,
  output logic     stretchActive
);

  localparam int IDX_W = $clog2(BIT_COUNT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BIT_COUNT - 1);

  sclState_e        st, stNext;
  logic [IDX_W-1:0] bitIdx;
  logic             byteSeen;
  logic             doRise, doFall;

  always_comb begin
    stNext = st;
    ctrl   = '0;
    doRise = 1'b0;
    doFall = 1'b0;
    case (st)
      ST_UNCFG: begin
        ctrl.cntClr = 1'b1;
        if (cfgLoad) begin
          stNext       = ST_LOW;
          ctrl.loadDiv = 1'b1;
          doFall       = 1'b1;
        end
      end
      ST_LOW: begin
        if (halfDone) begin
          ctrl.cntClr = 1'b1;
          if (bitIdx == '0 && byteSeen) begin
            stNext = ST_WAIT;
          end else begin
            stNext = ST_HIGH;
            doRise = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        ctrl.cntClr = 1'b1;
        if (sclHigh) begin
          stNext = ST_HIGH;
          doRise = 1'b1;
        end
      end
      default: begin
        if (halfDone) begin
          ctrl.cntClr = 1'b1;
          stNext      = ST_LOW;
          doFall      = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st          <= ST_UNCFG;
      sclDriveLow <= 1'b0;
      riseStb     <= 1'b0;
      fallStb     <= 1'b0;
      byteEndStb  <= 1'b0;
      bitIdx      <= '0;
      byteSeen    <= 1'b0;
    end else begin
      st          <= stNext;
      sclDriveLow <= (stNext == ST_LOW);
      riseStb     <= doRise;
      fallStb     <= doFall;
      byteEndStb  <= doFall && (st == ST_HIGH) && (bitIdx == LAST_IDX);
      if (doFall && st == ST_HIGH) begin
        if (bitIdx == LAST_IDX) begin
          bitIdx   <= '0;
          byteSeen <= 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  assign ackSlot       = (bitIdx == LAST_IDX);
  assign stretchActive = (st == ST_WAIT);

  p_released_unconfigured_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_UNCFG) |-> (!sclDriveLow && !riseStb && !fallStb && !byteEndStb));

  p_stretch_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    stretchActive |-> !sclDriveLow);

  p_wait_at_frame_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    stretchActive |-> (bitIdx == '0 && byteSeen));

  p_strobe_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb));

  p_frame_end_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteEndStb |-> (fallStb && bitIdx == '0));

  p_fall_pulls_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> sclDriveLow);

endmodule

// File: rtl/scl_boot_gen.sv
module scl_boot_gen
  import scl_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_COUNT   = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic [1:0] refCode,
  input  logic       fastSel,
  input  logic       sclIn,
  output logic       sclDriveLow,
  output logic       riseStb,
  output logic       fallStb,
  output logic       byteEndStb,
  output logic       ackSlot,
  output logic       stretchActive
);

  sclCtrl_t ctrl;
  logic     halfDone;
  logic     sclHigh;

  scl_gen_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .refCode  (refCode),
    .fastSel  (fastSel),
    .sclIn    (sclIn),
    .halfDone (halfDone),
    .sclHigh  (sclHigh)
  );

  scl_gen_ctrl #(.BIT_COUNT(BIT_COUNT)) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgLoad       (cfgLoad),
    .halfDone      (halfDone),
    .sclHigh       (sclHigh),
    .ctrl          (ctrl),
    .sclDriveLow   (sclDriveLow),
    .riseStb       (riseStb),
    .fallStb       (fallStb),
    .byteEndStb    (byteEndStb),
    .ackSlot       (ackSlot),
    .stretchActive (stretchActive)
  );

endmodule

// File: tb/test_scl_boot_gen.sv
module test_scl_boot_gen;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgLoad;
  logic [1:0] refCode;
  logic       fastSel;
  logic       sclLine;
  logic       sclDriveLow, riseStb, fallStb, byteEndStb, ackSlot, stretchActive;
  logic       slaveHold;

  always #4 clk = ~clk;

  assign sclLine = (sclDriveLow || slaveHold) ? 1'b0 : 1'b1;

  scl_boot_gen i_scl_boot_gen (
    .clk           (clk),
    .rstN          (rstN),
    .cfgLoad       (cfgLoad),
    .refCode       (refCode),
    .fastSel       (fastSel),
    .sclIn         (sclLine),
    .sclDriveLow   (sclDriveLow),
    .riseStb       (riseStb),
    .fallStb       (fallStb),
    .byteEndStb    (byteEndStb),
    .ackSlot       (ackSlot),
    .stretchActive (stretchActive)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    nFall  = 0;
  int    lastFall = 0;
  int    lastRise = 0;
  int    expQ[$];
  int    halfCur = 0;
  int    holdH   = 0;
  bit    midHold = 0;
  int    holdCnt = -1;
  int    midCnt  = -1;
  string periodTag = "R2";
  bit    done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard and slave model
  always @(negedge clk) begin
    cyc++;
    if (riseStb) lastRise = cyc;
    if (fallStb) begin
      if (nFall > 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, periodTag, "unexpected fall strobe", nFall, 0);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc - lastFall == e, periodTag, "fall-to-fall interval", cyc - lastFall, e);
        end
        check(cyc - lastRise == halfCur, "R1", "high phase length", cyc - lastRise, halfCur);
      end
      check(ackSlot == ((nFall % 9) == 8), "R7", "ack flag after fall", ackSlot, (nFall % 9) == 8);
      check(byteEndStb == (nFall > 0 && (nFall % 9) == 0), "R7", "frame end strobe",
            byteEndStb, nFall > 0 && (nFall % 9) == 0);
      if (midHold && (nFall % 9) == 3 && midCnt < 0) begin
        slaveHold = 1'b1;
        midCnt = 0;
      end
      lastFall = cyc;
      nFall++;
    end
    // frame-boundary stretch
    if (holdCnt >= 0) begin
      holdCnt++;
      if (holdCnt == halfCur + holdH - 1)
        check(stretchActive == 1'b1, "R6", "stretch flag during hold", stretchActive, 1);
      if (holdCnt == halfCur + holdH) begin
        slaveHold = 1'b0;
        holdCnt = -1;
      end
    end else if (byteEndStb && holdH > 0) begin
      slaveHold = 1'b1;
      holdCnt = 0;
    end
    // mid-frame hold
    if (midCnt >= 0 && !fallStb) begin
      midCnt++;
      if (midCnt == halfCur + 1)
        check(stretchActive == 1'b0, "R8", "no stretch flag mid-frame", stretchActive, 0);
      if (midCnt == halfCur + halfCur / 2) begin
        slaveHold = 1'b0;
        midCnt = -1;
      end
    end
  end

  task automatic runConfig(input logic [1:0] code, input logic fast, input int div,
                           input int nInt, input int h, input bit mid, input bit relock);
    bit quiet;
    @(negedge clk);
    rstN = 1'b0;
    cfgLoad = 1'b0;
    refCode = code;
    fastSel = fast;
    slaveHold = 1'b0;
    holdCnt = -1;
    midCnt = -1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sclLine !== 1'b1 || riseStb || fallStb || byteEndStb) quiet = 1'b0;
    end
    check(quiet, "R3", "line released and no strobes before load", quiet, 1);
    halfCur = div / 2;
    holdH = h;
    midHold = mid;
    nFall = 0;
    periodTag = relock ? "R4" : "R2";
    for (int n = 1; n <= nInt; n++) begin
      int b;
      b = (n - 1) % 9;
      // R5: frame-start bit after the first frame waits on the line
      expQ.push_back(div + ((b == 0 && n > 9) ? 3 + h : 0));
    end
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    if (relock) begin
      repeat (div * 2 + 5) @(negedge clk);
      refCode = ~code;
      fastSel = ~fast;
      cfgLoad = 1'b1;
      @(negedge clk);
      cfgLoad = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    cfgLoad = 1'b0;
    refCode = 2'd0;
    fastSel = 1'b0;
    slaveHold = 1'b0;
    // R2 and R5 (unstretched frame start) over every divider entry
    runConfig(2'd0, 1'b0, 1008, 11, 0, 0, 0);
    runConfig(2'd0, 1'b1, 256,  11, 0, 0, 0);
    runConfig(2'd1, 1'b0, 752,  11, 0, 0, 0);
    runConfig(2'd1, 1'b1, 192,  11, 0, 0, 0);
    runConfig(2'd2, 1'b0, 512,  11, 0, 0, 0);
    runConfig(2'd2, 1'b1, 128,  11, 0, 0, 0);
    runConfig(2'd3, 1'b0, 336,  11, 0, 0, 0);
    runConfig(2'd3, 1'b1, 96,   11, 0, 0, 0);
    // R5, R6 with a slave hold; R8 with a mid-frame hold
    runConfig(2'd3, 1'b1, 96, 20, 7, 1, 0);
    // R4: a second load with other inputs is ignored
    runConfig(2'd1, 1'b1, 192, 11, 0, 0, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule